// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by reading descriptors from a two-level translation table in memory. A translation-table base input gives the location of the 16 KB first-level table. A walk starts when a request is accepted on a valid/ready port. The walker then issues word reads on a memory request/response port and reports the result with a single-cycle done pulse.

The first-level descriptor can end the walk in two ways: as a 1 MB section mapping or as a fault. It can also point to a second-level table, either a coarse table of 1 KB or a fine table of 4 KB. A second-level descriptor maps a 64 KB, 4 KB or 1 KB page, or it is a fault. The result gives the physical address, the domain taken from the first-level descriptor, the access-permission bits, the cacheable/bufferable bits and a fault flag. The walker does not check permissions, does not cache translations and never writes the tables.

Back-pressure rules: a walk request moves only in a cycle where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is high only while the walker is idle, so there is at most one walk in flight. A memory read moves when `mem_req_valid_o` and `mem_req_ready_i` are both high. Until that handshake, the walker holds the request valid and keeps the address stable. The response channel has no back-pressure: the walker always takes `mem_rsp_valid_i` while it waits, and it has only one read outstanding.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `req_ready_o`=1, `busy_o`=0, `done_o`=0 and `mem_req_valid_o`=0.
- R2: The first read of a walk is at {ttb[31:14], va[31:20], 2'b00}, where ttb and va are the values captured when the request is accepted.
- R3: A first-level descriptor d with d[1:0]=2'b10 (section) ends the walk after one read. The outputs are pa={d[31:20], va[19:0]}, dom=d[8:5], ap={6'b0, d[11:10]}, cb=d[3:2] and fault=0.
- R4: A first-level descriptor with d[1:0]=2'b00 ends the walk after one read with fault=1 and with pa, dom, ap and cb all zero.
- R5: A first-level descriptor with d[1:0]=2'b01 points to a coarse table. The second read is at {d[31:10], va[19:12], 2'b00}.
- R6: A first-level descriptor with d[1:0]=2'b11 points to a fine table. The second read is at {d[31:12], va[19:10], 2'b00}.
- R7: A second-level descriptor e with e[1:0]=2'b01 gives pa={e[31:16], va[15:0]} and ap=e[11:4]. With e[1:0]=2'b10 it gives pa={e[31:12], va[11:0]} and ap=e[11:4]. With e[1:0]=2'b11 it gives pa={e[31:10], va[9:0]} and ap={6'b0, e[5:4]}. In all three cases cb=e[3:2], dom comes from the first-level descriptor bits [8:5], and fault=0.
- R8: A second-level descriptor with e[1:0]=2'b00 ends the walk with fault=1 and with pa, dom, ap and cb all zero.
- R9: `busy_o` is high from the cycle after acceptance through the done cycle. A request presented while busy has no effect. `done_o` lasts exactly one cycle, after which the walker is idle.
- R10: A memory read request is held with a stable address until `mem_req_ready_i`. After that handshake, no new read is issued until the response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ttb_i | input | 32 | Translation-table base, bits [31:14] used |
| req_valid_i | input | 1 | Walk request valid |
| req_ready_o | output | 1 | Walker idle, request can be accepted |
| req_va_i | input | 32 | Virtual address to translate |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse, result outputs valid |
| fault_o | output | 1 | Walk ended on a fault descriptor |
| pa_o | output | 32 | Physical address |
| dom_o | output | 4 | Domain from first-level descriptor |
| ap_o | output | 8 | Access-permission bits |
| cb_o | output | 2 | Cacheable/bufferable bits |
| mem_req_valid_o | output | 1 | Memory word read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_addr_o | output | 32 | Word read address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data (descriptor) |

## Verification
The bench drives every first-level and second-level descriptor kind, with random stall patterns on both memory channels. It aims at the address bits that differ between coarse and fine table indexing: a walker that mixes them up reads the wrong word and returns an unrelated translation. It also covers the page sizes where the physical address splits at bit 16, 12 or 10: a wrong split corrupts the low address bits only for some virtual addresses, so random addresses with all-ones and all-zeros corners are used. A request held high for a whole walk checks that a walker which re-accepts while busy is caught, because it would start an extra read or latch a new address in the middle of a walk.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int ADDR_W = 32;
  localparam int DOM_W  = 4;
  localparam int AP_W   = 8;
  localparam int CB_W   = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    L1_FAULT = 2'b00, L1_COARSE = 2'b01, L1_SECTION = 2'b10, L1_FINE = 2'b11
  } l1_kind_e;

  typedef enum logic [1:0] {
    L2_FAULT = 2'b00, L2_LARGE = 2'b01, L2_SMALL = 2'b10, L2_TINY = 2'b11
  } l2_kind_e;

  typedef struct packed {
    logic              fault;
    logic [ADDR_W-1:0] pa;
    logic [DOM_W-1:0]  dom;
    logic [AP_W-1:0]   ap;
    logic [CB_W-1:0]   cb;
  } walk_result_t;
endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr
  import pgwalk_pkg::*;
(
  input  logic              second_lvl_i,
  input  logic              fine_tbl_i,
  input  logic [ADDR_W-1:0] ttb_i,
  input  logic [ADDR_W-1:0] tbl_desc_i,
  input  logic [ADDR_W-1:0] va_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] l1_addr, coarse_addr, fine_addr;

  always_comb begin
    l1_addr     = {ttb_i[31:14], va_i[31:20], 2'b00};
    coarse_addr = {tbl_desc_i[31:10], va_i[19:12], 2'b00};
    fine_addr   = {tbl_desc_i[31:12], va_i[19:10], 2'b00};
    if (!second_lvl_i)   addr_o = l1_addr;
    else if (fine_tbl_i) addr_o = fine_addr;
    else                 addr_o = coarse_addr;
  end
endmodule

// File: rtl/pgwalk_decode.sv
module pgwalk_decode
  import pgwalk_pkg::*;
(
  input  logic              second_lvl_i,
  input  logic [ADDR_W-1:0] desc_i,
  input  logic [ADDR_W-1:0] va_i,
  input  logic [DOM_W-1:0]  l1_dom_i,
  output logic              leaf_o,
  output walk_result_t      res_o
);
  always_comb begin
    res_o  = '0;
    leaf_o = 1'b1;
    if (!second_lvl_i) begin
      unique case (l1_kind_e'(desc_i[1:0]))
        L1_FAULT:   res_o.fault = 1'b1;
        L1_SECTION: begin
          res_o.pa  = {desc_i[31:20], va_i[19:0]};
          res_o.dom = desc_i[8:5];
          res_o.ap  = {{(AP_W-2){1'b0}}, desc_i[11:10]};
          res_o.cb  = desc_i[3:2];
        end
        L1_COARSE, L1_FINE: leaf_o = 1'b0;
      endcase
    end else begin
      unique case (l2_kind_e'(desc_i[1:0]))
        L2_FAULT: res_o.fault = 1'b1;
        L2_LARGE: begin
          res_o.pa = {desc_i[31:16], va_i[15:0]};
          res_o.ap = desc_i[11:4];
        end
        L2_SMALL: begin
          res_o.pa = {desc_i[31:12], va_i[11:0]};
          res_o.ap = desc_i[11:4];
        end
        L2_TINY: begin
          res_o.pa = {desc_i[31:10], va_i[9:0]};
          res_o.ap = {{(AP_W-2){1'b0}}, desc_i[5:4]};
        end
      endcase
      if (desc_i[1:0] != 2'b00) begin
        res_o.dom = l1_dom_i;
        res_o.cb  = desc_i[3:2];
      end
    end
  end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] ttb_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_va_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic [ADDR_W-1:0] pa_o,
  output logic [DOM_W-1:0]  dom_o,
  output logic [AP_W-1:0]   ap_o,
  output logic [CB_W-1:0]   cb_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [ADDR_W-1:0] mem_rsp_data_i
);
  walk_state_e       state_q;
  logic [ADDR_W-1:0] va_q, ttb_q, l1_desc_q;
  walk_result_t      res_q, dec_res;
  logic              dec_leaf;

  pgwalk_addr u_addr (
    .second_lvl_i (state_q == ST_L2_REQ),
    .fine_tbl_i   (l1_desc_q[1:0] == 2'b11),
    .ttb_i        (ttb_q),
    .tbl_desc_i   (l1_desc_q),
    .va_i         (va_q),
    .addr_o       (mem_addr_o)
  );

  pgwalk_decode u_dec (
    .second_lvl_i (state_q == ST_L2_WAIT),
    .desc_i       (mem_rsp_data_i),
    .va_i         (va_q),
    .l1_dom_i     (l1_desc_q[8:5]),
    .leaf_o       (dec_leaf),
    .res_o        (dec_res)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      va_q      <= '0;
      ttb_q     <= '0;
      l1_desc_q <= '0;
      res_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          va_q    <= req_va_i;
          ttb_q   <= ttb_i;
          state_q <= ST_L1_REQ;
        end
        ST_L1_REQ: if (mem_req_ready_i) state_q <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rsp_valid_i) begin
          l1_desc_q <= mem_rsp_data_i;
          if (dec_leaf) begin
            res_q   <= dec_res;
            state_q <= ST_DONE;
          end else begin
            state_q <= ST_L2_REQ;
          end
        end
        ST_L2_REQ: if (mem_req_ready_i) state_q <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_rsp_valid_i) begin
          res_q   <= dec_res;
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign busy_o          = (state_q != ST_IDLE);
  assign done_o          = (state_q == ST_DONE);
  assign mem_req_valid_o = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign fault_o         = res_q.fault;
  assign pa_o            = res_q.pa;
  assign dom_o           = res_q.dom;
  assign ap_o            = res_q.ap;
  assign cb_o            = res_q.cb;
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        fault_o,
  input logic [31:0] pa_o,
  input logic [3:0]  dom_o,
  input logic [7:0]  ap_o,
  input logic [1:0]  cb_o,
  input logic        mem_req_valid_o,
  input logic        mem_req_ready_i,
  input logic [31:0] mem_addr_o
);
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  a_r9_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> busy_o);

  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_addr_o)));

  a_r10_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_req_ready_i) |=> !mem_req_valid_o);

  a_r8_fault_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> (pa_o == 32'h0 && dom_o == 4'h0 && ap_o == 8'h0 && cb_o == 2'h0));

  a_r9_done_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));
endmodule

bind pgwalk_top pgwalk_chk chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .busy_o          (busy_o),
  .done_o          (done_o),
  .fault_o         (fault_o),
  .pa_o            (pa_o),
  .dom_o           (dom_o),
  .ap_o            (ap_o),
  .cb_o            (cb_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_addr_o      (mem_addr_o)
);

// File: tb/pgwalk_top_tb_top.sv
`timescale 1ns/1ps
module pgwalk_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ttb = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        busy, done, fault;
  logic [31:0] pa;
  logic [3:0]  dom;
  logic [7:0]  ap;
  logic [1:0]  cb;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #10 clk = ~clk;

  pgwalk_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ttb_i(ttb),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
    .busy_o(busy), .done_o(done), .fault_o(fault), .pa_o(pa), .dom_o(dom),
    .ap_o(ap), .cb_o(cb), .mem_req_valid_o(mem_req_valid),
    .mem_req_ready_i(mem_req_ready), .mem_addr_o(mem_addr),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_data_i(mem_rsp_data)
  );

  int compared = 0;
  int mismatched = 0;
  bit [31:0] mem [bit [31:0]];
  int        rd_cnt = 0;
  bit [31:0] rd_addr [2];

  typedef struct packed {
    bit        f;
    bit [31:0] pa;
    bit [3:0]  dom;
    bit [7:0]  ap;
    bit [1:0]  cb;
    bit [1:0]  n;
    bit [31:0] a1;
    bit [31:0] a2;
  } exp_t;

  function automatic bit [31:0] mem_rd(bit [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  function automatic exp_t model(bit [31:0] va, bit [31:0] tb);
    exp_t e = '0;
    bit [31:0] d, x;
    e.a1 = {tb[31:14], va[31:20], 2'b00};
    d = mem_rd(e.a1);
    e.n = 1;
    case (d[1:0])
      2'b00: e.f = 1;
      2'b10: begin
        e.pa = {d[31:20], va[19:0]}; e.dom = d[8:5];
        e.ap = {6'b0, d[11:10]}; e.cb = d[3:2];
      end
      default: begin
        e.n = 2;
        e.a2 = (d[1:0] == 2'b01) ? {d[31:10], va[19:12], 2'b00}
                                 : {d[31:12], va[19:10], 2'b00};
        x = mem_rd(e.a2);
        if (x[1:0] == 2'b00) e.f = 1;
        else begin
          e.dom = d[8:5]; e.cb = x[3:2];
          case (x[1:0])
            2'b01:   begin e.pa = {x[31:16], va[15:0]}; e.ap = x[11:4]; end
            2'b10:   begin e.pa = {x[31:12], va[11:0]}; e.ap = x[11:4]; end
            default: begin e.pa = {x[31:10], va[9:0]};  e.ap = {6'b0, x[5:4]}; end
          endcase
        end
      end
    endcase
    return e;
  endfunction

  task automatic chk(string req, bit ok, string what, bit [63:0] act, bit [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory responder: random ready, random response latency
  initial begin
    bit        pend = 0, hs = 0;
    int        dly = 0;
    bit [31:0] paddr = '0, hs_addr = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1; mem_rsp_data = mem_rd(paddr); pend = 0;
        end else dly--;
      end
      if (hs) begin
        if (rd_cnt < 2) rd_addr[rd_cnt] = hs_addr;
        rd_cnt++;
        pend = 1; paddr = hs_addr; dly = $urandom % 3; hs = 0;
      end
      if (pend && mem_req_valid) chk("R10", 0, "read issued while outstanding", 1, 0);
      mem_req_ready = !pend && (($urandom % 4) != 0);
      hs = mem_req_valid && mem_req_ready && rst_n;
      hs_addr = mem_addr;
    end
  end

  task automatic walk(bit [31:0] va, bit hold_valid);
    exp_t e;
    int   t = 0;
    e = model(va, ttb);
    rd_cnt = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_va = va; req_valid = 1'b1;
    @(negedge clk);
    if (!hold_valid) req_valid = 1'b0;
    chk("R9", busy == 1'b1, "busy after accept", busy, 1);
    while (!done && t < 300) begin
      if (hold_valid) req_va = $urandom;
      @(negedge clk); t++;
    end
    req_valid = 1'b0;
    if (t >= 300) begin
      chk("R9", 0, "watchdog: no done", 0, 1);
      return;
    end
    chk("R2", rd_addr[0] == e.a1, "first-level address", rd_addr[0], e.a1);
    chk(e.n == 1 ? "R3/R4" : "R5/R6", rd_cnt == int'(e.n), "read count", rd_cnt, e.n);
    if (e.n == 2) chk(e.a2[12] != e.a2[11] ? "R5/R6" : "R6/R5",
                      rd_addr[1] == e.a2, "second-level address", rd_addr[1], e.a2);
    chk(e.n == 1 ? "R3/R4" : "R7/R8", fault == e.f, "fault", fault, e.f);
    chk(e.n == 1 ? "R3/R4" : "R7/R8", pa == e.pa, "pa", pa, e.pa);
    chk(e.n == 1 ? "R3/R4" : "R7/R8", {dom, ap, cb} == {e.dom, e.ap, e.cb},
        "dom/ap/cb", {dom, ap, cb}, {e.dom, e.ap, e.cb});
    @(negedge clk);
    chk("R9", !done && !busy && req_ready, "done one cycle then idle",
        {done, busy, req_ready}, 3'b001);
    repeat (3) @(negedge clk);
    chk("R9", rd_cnt == int'(e.n), "no extra reads after done", rd_cnt, e.n);
  endtask

  // build one table path; k1 = first-level kind, k2 = second-level kind
  task automatic setup(bit [31:0] va, bit [1:0] k1, bit [1:0] k2);
    bit [31:0] d, a2;
    mem.delete();
    ttb = {$urandom, 14'h0} | ($urandom & 32'h3FFF);
    d = {$urandom} ; d[1:0] = k1;
    if (k1 != 2'b00 || ($urandom % 2)) mem[{ttb[31:14], va[31:20], 2'b00}] = d;
    if (k1 == 2'b01 || k1 == 2'b11) begin
      a2 = (k1 == 2'b01) ? {d[31:10], va[19:12], 2'b00} : {d[31:12], va[19:10], 2'b00};
      d = $urandom; d[1:0] = k2;
      mem[a2] = d;
    end
  endtask

  initial begin
    int wd = 0;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R1", req_ready && !busy && !done && !mem_req_valid, "reset outputs",
        {req_ready, busy, done, mem_req_valid}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", req_ready && !busy && !done && !mem_req_valid, "idle after reset",
        {req_ready, busy, done, mem_req_valid}, 4'b1000);
    // directed: every kind pair at address corners
    for (int k1 = 0; k1 < 4; k1++)
      for (int k2 = 0; k2 < 4; k2++) begin
        setup(32'hFFFF_FFFF, k1[1:0], k2[1:0]); walk(32'hFFFF_FFFF, 0);
        setup(32'h0000_0000, k1[1:0], k2[1:0]); walk(32'h0000_0000, 0);
        setup(32'h0005_5A5A, k1[1:0], k2[1:0]); walk(32'h0005_5A5A, 1); // R9 held request
      end
    // random walks
    for (int i = 0; i < 400; i++) begin
      bit [31:0] va = $urandom;
      setup(va, 2'($urandom), 2'($urandom));
      walk(va, ($urandom % 5) == 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(20ns * 150000);
    chk("R9", 0, "global watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule